// File: doc/BRIEF.md
# Truncatable Decade Counter

This block is a synchronous digit counter. It moves up by one on each clock edge where its count-enable input is high. With no feedback selected it steps through the decimal digits 0 to 9 and then goes back to 0. Two zero-request inputs are ANDed, so the count is cleared to zero only when both are high on the same edge. A clear always wins over counting.

A feedback mask shortens the cycle. Each mask bit picks the count bit in the same position. When every picked bit is 1 in the value the counter would load next, the counter loads zero instead. This means the first value that contains all the picked bits is never shown. A mask of 1000 gives a count of eight states (0..7), 0101 gives five states and 0010 gives two states. The match is taken on the would-be next value without a register in between, so the trigger value is never held for even one cycle.

A terminal-count output marks each wrap cycle. It is combinational and is high in the cycle whose clock edge takes the count back to zero by counting.

Top module: `bcd_trunc_counter`

## Requirements
- R1: While `rst_n` is low the count is 0, and after release it stays 0 until the first accepted count pulse.
- R2: On an edge with `count_en` high and no clear, the count rises by exactly one unless it wraps. With `count_en` low and no clear, the count holds.
- R3: With `fb_mask` = 0000 the count runs 0,1,...,9 and the step after 9 is 0. The count never goes above 9.
- R4: A single zero-request input that is high while the other is low has no effect on the count.
- R5: When `zero_a` and `zero_b` are both high at an edge, the count is 0 after that edge, whatever `count_en` and the present count are.
- R6: With `fb_mask` = 1000 (bit 3 selected), the count runs 0..7 and the step after 7 is 0. The value 8 never appears.
- R7: Mask bit i selects count bit i. A nonzero mask makes the counter load 0 in place of any next value in which every selected bit is 1. For example, mask 0101 gives 0..4 and mask 0010 gives 0,1. Bits that are not selected do not matter.
- R8: A nonzero mask whose selected bits never all appear in 0..9 (for example 1100 or 1010) leaves the plain decimal sequence unchanged.
- R9: `term_cnt` is high exactly when `count_en` is high, the two zero requests are not both high, and the next count is 0 because of a wrap or a truncation. Otherwise it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| count_en | input | 1 | Count pulse; the count advances on an edge where it is high |
| zero_a | input | 1 | First zero request; works only together with `zero_b` |
| zero_b | input | 1 | Second zero request; works only together with `zero_a` |
| fb_mask | input | 4 | Feedback select; bit i routes count bit i into the truncation AND |
| count | output | 4 | Present count value |
| term_cnt | output | 1 | High in a cycle whose edge returns the count to zero by counting |

## Verification
Directed runs cover each mask that the requirements name. An empty mask separates the plain decimal wrap from any truncation. A mask of 1000 and a mask of 0101 each show that the trigger value is skipped and not held for a cycle. A mask of 0010 gives the shortest cycle. A mask of 1100 shows that an out-of-reach pattern leaves the decimal cycle alone. Zero requests are applied one at a time to show they are ignored, and both together, with and without a count pulse, to show that clear wins. Seeded random cycles then change the mask while the counter runs. This catches designs that decode the present value instead of the next one, or that compare against a fixed terminal value.

// File: rtl/bcd_trunc_pkg.sv
package bcd_trunc_pkg;

  // Why the register loads what it loads on a given edge
  typedef enum logic [2:0] {
    LOAD_HOLD  = 3'd0,
    LOAD_STEP  = 3'd1,
    LOAD_WRAP  = 3'd2,
    LOAD_TRUNC = 3'd3,
    LOAD_CLEAR = 3'd4
  } load_cause_e;

endpackage

// File: rtl/bcd_trunc_step.sv
module bcd_trunc_step #(
  parameter int BASE  = 10,
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] cand,
  output logic             wrap
);
  localparam logic [WIDTH-1:0] LAST = WIDTH'(BASE - 1);
  localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);

  // Next digit in the natural BASE cycle
  function automatic logic [WIDTH-1:0] next_digit(input logic [WIDTH-1:0] v);
    if (v >= LAST) return '0;
    return v + ONE;
  endfunction

  always_comb begin
    cand = next_digit(cur);
    wrap = (cur >= LAST);
  end

  // R3: a wrap must hand back zero
  always_comb begin
    if (wrap) a_wrap_zero_r3: assert (cand == '0);
  end
endmodule

// File: rtl/bcd_trunc_fb.sv
module bcd_trunc_fb #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cand,
  input  logic [WIDTH-1:0] mask,
  output logic             hit
);
  logic [WIDTH-1:0] term;

  // An unselected position contributes a 1 to the AND
  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_term
      assign term[gi] = ~mask[gi] | cand[gi];
    end
  endgenerate

  function automatic logic any_selected(input logic [WIDTH-1:0] m);
    return |m;
  endfunction

  assign hit = any_selected(mask) & (&term);

  // R7: a hit implies every selected bit is present in the candidate
  always_comb begin
    if (hit) a_hit_cover_r7: assert ((cand & mask) == mask && mask != '0);
  end
endmodule

// File: rtl/bcd_trunc_reg.sv
module bcd_trunc_reg
  import bcd_trunc_pkg::*;
#(
  parameter int BASE  = 10,
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic             trunc,
  input  logic             wrap,
  input  logic [WIDTH-1:0] cand,
  output logic [WIDTH-1:0] q,
  output load_cause_e      cause
);
  localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);
  localparam logic [WIDTH-1:0] LAST = WIDTH'(BASE - 1);

  logic [WIDTH-1:0] d;

  // Clear first, then truncation, then natural step
  always_comb begin
    d     = q;
    cause = LOAD_HOLD;
    if (clr) begin
      d     = '0;
      cause = LOAD_CLEAR;
    end else if (adv && trunc) begin
      d     = '0;
      cause = LOAD_TRUNC;
    end else if (adv) begin
      d     = cand;
      cause = wrap ? LOAD_WRAP : LOAD_STEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !clr) |=> $stable(q));
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cause == LOAD_STEP) |=> (q == $past(q) + ONE));
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (q == '0));
  p_trunc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && trunc && !clr) |=> (q == '0));
  p_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (q <= LAST));
endmodule

// File: rtl/bcd_trunc_counter.sv
module bcd_trunc_counter
  import bcd_trunc_pkg::*;
#(
  parameter int BASE  = 10,
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             count_en,
  input  logic             zero_a,
  input  logic             zero_b,
  input  logic [WIDTH-1:0] fb_mask,
  output logic [WIDTH-1:0] count,
  output logic             term_cnt
);
  logic [WIDTH-1:0] cand;
  logic             wrap;
  logic             fb_hit;
  logic             clr_req;
  logic             rolled;
  load_cause_e      cause;

  assign clr_req = zero_a & zero_b;

  bcd_trunc_step #(.BASE(BASE), .WIDTH(WIDTH)) u_step (
    .cur (count),
    .cand(cand),
    .wrap(wrap)
  );

  bcd_trunc_fb #(.WIDTH(WIDTH)) u_fb (
    .cand(cand),
    .mask(fb_mask),
    .hit (fb_hit)
  );

  bcd_trunc_reg #(.BASE(BASE), .WIDTH(WIDTH)) u_reg (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (clr_req),
    .adv  (count_en),
    .trunc(fb_hit),
    .wrap (wrap),
    .cand (cand),
    .q    (count),
    .cause(cause)
  );

  assign rolled   = wrap | fb_hit;
  assign term_cnt = count_en & ~clr_req & rolled;

  p_tc_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    term_cnt |=> (count == '0));
  p_tc_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    term_cnt |-> (cause == LOAD_WRAP || cause == LOAD_TRUNC));
  p_single_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((zero_a ^ zero_b) && !count_en) |=> $stable(count));
endmodule

// File: tb/tb_bcd_trunc_counter.sv
module tb_bcd_trunc_counter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       count_en = 1'b0;
  logic       zero_a = 1'b0;
  logic       zero_b = 1'b0;
  logic [3:0] fb_mask = 4'd0;
  logic [3:0] count;
  logic       term_cnt;

  int n_chk = 0;
  int n_bad = 0;
  int model = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bcd_trunc_counter dut (
    .clk(clk), .rst_n(rst_n), .count_en(count_en), .zero_a(zero_a),
    .zero_b(zero_b), .fb_mask(fb_mask), .count(count), .term_cnt(term_cnt)
  );

  // Value reached by counting alone: decimal cycle, then mask substitution
  function automatic int counted(input int cur, input int m);
    int c;
    c = (cur + 1) % 10;
    if (m != 0 && (c & m) == m) c = 0;
    return c;
  endfunction

  function automatic int ref_next(input int cur, input bit en, input bit a,
                                  input bit b, input int m);
    if (a && b) return 0;
    if (!en) return cur;
    return counted(cur, m);
  endfunction

  function automatic bit ref_tc(input int cur, input bit en, input bit a,
                                input bit b, input int m);
    return en && !(a && b) && counted(cur, m) == 0;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One cycle: drive at negedge, check flag before the edge, count after
  task automatic cyc(input bit en, input bit a, input bit b, input int m,
                     input string tag);
    int e;
    count_en = en; zero_a = a; zero_b = b; fb_mask = 4'(m);
    #1;
    check({tag, " term_cnt R9"}, int'(term_cnt), int'(ref_tc(model, en, a, b, m)));
    e = ref_next(model, en, a, b, m);
    @(posedge clk);
    @(negedge clk);
    check({tag, " count"}, int'(count), e);
    model = e;
  endtask

  task automatic run_seq(input int m, input int steps, input string tag);
    for (int i = 0; i < steps; i++) cyc(1'b1, 1'b0, 1'b0, m, tag);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1187));
    count_en = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 count in reset", int'(count), 0);
    rst_n = 1'b1;
    count_en = 1'b0;
    @(negedge clk);
    check("R1 count after release", int'(count), 0);
    check("R1 term_cnt after release", int'(term_cnt), 0);
    model = 0;

    // R3: plain decimal cycle, twice around
    run_seq(0, 20, "R3 decade");
    // R2: hold with no pulse
    cyc(1'b1, 1'b0, 1'b0, 0, "R2 step");
    repeat (3) cyc(1'b0, 1'b0, 1'b0, 0, "R2 hold");
    // R4: one request alone, with and without a pulse
    cyc(1'b0, 1'b1, 1'b0, 0, "R4 a alone");
    cyc(1'b0, 1'b0, 1'b1, 0, "R4 b alone");
    cyc(1'b1, 1'b1, 1'b0, 0, "R4 a alone counting");
    // R5: both requests, with and without a pulse
    cyc(1'b1, 1'b0, 1'b0, 0, "R5 pre");
    cyc(1'b1, 1'b1, 1'b1, 0, "R5 clear while counting");
    run_seq(0, 6, "R5 refill");
    cyc(1'b0, 1'b1, 1'b1, 0, "R5 clear idle");

    // R6: bit 3 feedback, value 8 must never show
    run_seq(8, 24, "R6 mask1000");
    // R7: masks 0101 and 0010
    cyc(1'b0, 1'b1, 1'b1, 8, "R7 pre clear");
    run_seq(5, 15, "R7 mask0101");
    cyc(1'b0, 1'b1, 1'b1, 5, "R7 pre clear");
    run_seq(2, 6, "R7 mask0010");
    // R8: out-of-reach patterns
    cyc(1'b0, 1'b1, 1'b1, 2, "R8 pre clear");
    run_seq(12, 22, "R8 mask1100");
    run_seq(10, 12, "R8 mask1010");

    // Random mix, mask occasionally retargeted mid-run
    begin
      int m = 0;
      for (int i = 0; i < 3000; i++) begin
        bit en, a, b;
        if ($urandom_range(0, 15) == 0) m = $urandom_range(0, 15);
        en = ($urandom_range(0, 3) != 0);
        a  = ($urandom_range(0, 7) == 0);
        b  = ($urandom_range(0, 7) == 0);
        cyc(en, a, b, m, "R2 R7 random");
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule